// File: doc/BRIEF.md
# Half-Row Composite Sync Generator

This block produces the active-low composite sync for a progressive, PAL-timed raster. It runs from one 16 MHz clock. Each 64 us line is split into two 32 us half-rows of 512 clocks. A second counter numbers the half-rows of a field from 0 to 625 and returns to 0, which gives a 50 Hz field rate.

At each half-row boundary the block chooses one of four pulse kinds for the coming half-row:
- no pulse;
- a 4 us line-sync pulse;
- a 2 us equalizing pulse;
- a 30 us broad pulse.

The chosen shape is loaded as a 16-slot pattern into a shift register. The register advances one slot every 2 us, and its low bit is the sync output. The vertical interval takes the first 16 half-rows: equalizing, then broad, then equalizing again. The last equalizing group has one extra half-row because the raster is not interlaced.

Downstream logic uses the half-row index, the clock position inside the half-row and a one-cycle field-start strobe to place the picture and to lock to the field.

Top module: `pal_halfrow_sync`

## Requirements
- R1: When the synchronous reset `rst` is high, and in the first cycle after it falls, `half_row` and `hr_pos` are 0, `field_start` is 1 and `sync_n` is 0 (slot 0 of an equalizing half-row).
- R2: `hr_pos` rises by one each clock, from 0 to 16*SLOT_CLKS-1, and then returns to 0. `half_row` rises by one in the cycle in which `hr_pos` returns to 0.
- R3: After half-row FIELD_HR-1, `half_row` returns to 0. `field_start` is 1 exactly in the cycles where `half_row` is 0 and `hr_pos` is 0.
- R4: In half-rows 0 to 4, `sync_n` is low for slot 0 only. A slot is `hr_pos / SLOT_CLKS`.
- R5: In half-rows 5 to 9, `sync_n` is low for slots 0 to 14 and high in slot 15.
- R6: In half-rows 10 to 15, `sync_n` is low for slot 0 only.
- R7: In even half-rows from 16 upward, `sync_n` is low for slots 0 and 1 and high in all other slots.
- R8: In odd half-rows from 16 upward, `sync_n` stays high for the whole half-row.
- R9: `sync_n` changes level only in cycles where `hr_pos` is a multiple of SLOT_CLKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (16 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | output | 1 | Registered composite sync, active low |
| field_start | output | 1 | One-cycle strobe at half-row 0, position 0 |
| half_row | output | $clog2(FIELD_HR) | Index of the current half-row in the field |
| hr_pos | output | $clog2(16*SLOT_CLKS) | Clock position inside the current half-row |

## Verification
A corrupted half-row counter shows at the ports within one half-row: the pulse kind loaded at the next boundary no longer matches the index, and a wrong index also moves `field_start` off its place. A shift register that loses or gains a bit shows as a pulse edge at the wrong slot within 2 us of the fault. The bench models position and pulse level from the requirements alone and compares every output on every clock over several whole fields, so each fault is caught in the cycle it first reaches a port. The bench uses short slots and a short field to keep the runs short.

// File: rtl/pal_halfrow_sync.sv
module pal_halfrow_sync #(
  parameter int SLOT_CLKS = 32,
  parameter int FIELD_HR  = 626,
  parameter int EQ_A      = 5,
  parameter int BROAD     = 5,
  parameter int EQ_B      = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  output logic                              sync_n,
  output logic                              field_start,
  output logic [$clog2(FIELD_HR)-1:0]       half_row,
  output logic [$clog2(16*SLOT_CLKS)-1:0]   hr_pos
);
  localparam int HR_CLKS = 16 * SLOT_CLKS;
  localparam int HRW     = $clog2(FIELD_HR);
  localparam int PW      = $clog2(HR_CLKS);
  localparam int VS_END  = EQ_A + BROAD + EQ_B;

  function automatic logic [15:0] shape(input int unsigned h);
    int unsigned n;
    if (h < EQ_A)                n = 1;
    else if (h < EQ_A + BROAD)   n = 15;
    else if (h < VS_END)         n = 1;
    else                         n = (h % 2 == 0) ? 2 : 0;
    for (int i = 0; i < 16; i++) shape[i] = (i >= n);
  endfunction

  logic [15:0]    sr;
  logic [HRW-1:0] next_hr;
  wire pos_end  = hr_pos == PW'(HR_CLKS - 1);
  wire hr_end   = half_row == HRW'(FIELD_HR - 1);
  wire slot_end = (hr_pos % PW'(SLOT_CLKS)) == PW'(SLOT_CLKS - 1);

  assign next_hr = hr_end ? '0 : half_row + 1'b1;
  assign sync_n  = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_pos      <= '0;
      half_row    <= '0;
      sr          <= shape(0);
      field_start <= 1'b1;
    end else begin
      hr_pos <= pos_end ? '0 : hr_pos + 1'b1;
      if (pos_end) begin
        half_row    <= next_hr;
        sr          <= shape(int'(next_hr));
        field_start <= (next_hr == '0);
      end else begin
        field_start <= 1'b0;
        if (slot_end) sr <= {1'b1, sr[15:1]};
      end
    end
  end

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    hr_pos != PW'(HR_CLKS - 1) |=> hr_pos == $past(hr_pos) + 1'b1);
  // R3
  field_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_pos == PW'(HR_CLKS - 1) && half_row == HRW'(FIELD_HR - 1))
      |=> (half_row == '0 && field_start));
  // R9
  slot_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_pos % PW'(SLOT_CLKS)) != '0 |-> $stable(sync_n));
  // R5
  broad_low_chk: assert property (@(posedge clk) disable iff (rst)
    (half_row >= HRW'(EQ_A) && half_row < HRW'(EQ_A + BROAD)
     && hr_pos < PW'(15 * SLOT_CLKS)) |-> !sync_n);
  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (half_row >= HRW'(VS_END) && half_row[0]) |-> sync_n);
endmodule

// File: tb/tb_pal_halfrow_sync.sv
module tb_pal_halfrow_sync;
  localparam int SC = 4;
  localparam int FH = 40;
  localparam int HC = 16 * SC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n, field_start;
  logic [$clog2(FH)-1:0]  half_row;
  logic [$clog2(HC)-1:0]  hr_pos;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pal_halfrow_sync #(.SLOT_CLKS(SC), .FIELD_HR(FH)) dut (
    .clk(clk), .rst(rst), .sync_n(sync_n), .field_start(field_start),
    .half_row(half_row), .hr_pos(hr_pos));

  function automatic int low_slots(input int h);
    if (h < 5)  return 1;
    if (h < 10) return 15;
    if (h < 16) return 1;
    return (h % 2 == 0) ? 2 : 0;
  endfunction

  function automatic string tag(input int h);
    if (h < 5)  return "R4";
    if (h < 10) return "R5";
    if (h < 16) return "R6";
    return (h % 2 == 0) ? "R7" : "R8";
  endfunction

  task automatic check(input int h, input int p, input string rq);
    bit es = !((p / SC) < low_slots(h));
    bit ef = (h == 0 && p == 0);
    tests++;
    if (half_row !== h || hr_pos !== p) begin
      fails++;
      $display("FAIL %s position: got hr=%0d pos=%0d exp hr=%0d pos=%0d",
               rq, half_row, hr_pos, h, p);
    end
    tests++;
    if (field_start !== ef) begin
      fails++;
      $display("FAIL R3 field_start at hr=%0d pos=%0d: got %0b exp %0b",
               h, p, field_start, ef);
    end
    tests++;
    if (sync_n !== es) begin
      fails++;
      $display("FAIL %s/R9 sync_n at hr=%0d pos=%0d: got %0b exp %0b",
               tag(h), h, p, sync_n, es);
    end
  endtask

  initial begin
    int h, p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(0, 0, "R1");
    rst = 1'b0;
    h = 0; p = 0;
    @(posedge clk); @(negedge clk);
    p = 1;
    check(h, p, "R1");
    for (int c = 0; c < 3 * FH * HC + 100; c++) begin
      @(posedge clk); @(negedge clk);
      p++;
      if (p == HC) begin
        p = 0;
        h = (h == FH - 1) ? 0 : h + 1;
      end
      check(h, p, (p == 0 && h == 0) ? "R3" : "R2");
    end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(0, 0, "R1");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 40000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule